// File: doc/BRIEF.md
# Thermal Event Comparator with Hysteresis

This block takes temperature samples from a converter and checks each one against three programmable limits: a high window limit, a low window limit and a critical limit. It reports three trip status bits that follow the raw comparisons. It also drives one event signal meant for an open-drain pin. The event can follow the temperature as a level, latch on every limit crossing until software clears it, or react only to the critical limit. Release points can be given hysteresis. The output has its own enable and polarity, and a shutdown control freezes the sample and the event.

Samples are 13-bit two's complement values in 0.0625°C steps. Limits are 10-bit two's complement values in 0.25°C steps, and the block scales them up by two bit positions before comparing. Samples arrive on a valid/ready stream. `samp_ready` is low for as long as shutdown is requested. A sample offered while ready is low is not taken, and the producer may hold it or drop it. A sample is accepted on any clock edge where valid and ready are both high. The limits and all configuration pins are plain levels that the block reads every cycle.

Top module: `therm_evt_cmp`

## Requirements
- R1: With limits scaled by four (two zero bits appended), `trip_crit` is 1 when the held sample is at or above the critical limit. `trip_hi` is 1 when the sample is strictly above the high limit. `trip_lo` is 1 when it is strictly below the low limit. All comparisons are signed.
- R2: The trip bits depend only on the held sample and the limits. Enable, polarity, mode, critical-only, hysteresis and clear do not change them.
- R3: `cfg_hyst` sets the hysteresis to 0, 24, 48 or 96 sample LSBs for codes 0, 1, 2 and 3.
  - The above-window alarm sets when the sample exceeds the high limit. It releases at or below the high limit minus the hysteresis.
  - The below-window alarm sets when the sample is below the low limit minus the hysteresis. It releases at or above the low limit.
  - The critical alarm sets at or above the critical limit. It releases below the critical limit minus the hysteresis.
- R4: In level mode (`cfg_latch_mode`=0, `cfg_crit_only`=0), the event is high while any of the three alarms is active.
- R5: With `cfg_crit_only`=1, only the critical alarm can raise the event.
- R6: In latch mode (`cfg_latch_mode`=1), any change of an alarm state latches the event. A one-cycle `evt_clr` releases it. In level mode `evt_clr` has no effect.
- R7: While the critical alarm is active, the event is high in every mode and `evt_clr` is ignored.
- R8: `evt_status` is the event gated by `cfg_evt_en`. `evt_pull` equals `evt_status` XOR `cfg_evt_pol`: pol 0 pulls down when active, and pol 1 pulls down when inactive or disabled.
- R9: While `cfg_shdn`=1:
  - `samp_ready` is 0 and the held sample does not change.
  - The alarm states and the event hold their values.
  - In latch mode, `evt_clr` still releases a latched, non-critical event.
- R10: A change to a limit changes the trip bits in the same cycle and the event at the next clock edge, with no new sample needed.
- R11: Reset clears the held sample, the alarm states and the event, so `evt_status` is 0 and `evt_pull` equals `cfg_evt_pol`.
- R12: An accepted sample shows on the trip bits after the clock edge that takes it. The event responds one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_valid | input | 1 | Sample valid |
| samp_ready | output | 1 | Sample ready, low during shutdown |
| samp_temp | input | 13 | Sample, two's complement, 0.0625°C LSB |
| lim_hi | input | 10 | High window limit, 0.25°C LSB |
| lim_lo | input | 10 | Low window limit, 0.25°C LSB |
| lim_crit | input | 10 | Critical limit, 0.25°C LSB |
| cfg_latch_mode | input | 1 | 1 = latched interrupt mode, 0 = level mode |
| cfg_crit_only | input | 1 | 1 = only the critical alarm raises the event |
| cfg_hyst | input | 2 | Hysteresis select |
| cfg_evt_en | input | 1 | Event output enable |
| cfg_evt_pol | input | 1 | 0 = active low, 1 = active high |
| cfg_shdn | input | 1 | Shutdown: freeze sample and event |
| evt_clr | input | 1 | One-cycle clear of a latched event |
| trip_crit | output | 1 | At or above the critical limit |
| trip_hi | output | 1 | Above the high limit |
| trip_lo | output | 1 | Below the low limit |
| evt_status | output | 1 | Event state after the enable, polarity independent |
| evt_pull | output | 1 | Pull-down enable for the open-drain pin |

## Verification
The bench walks samples that sit exactly on each limit and on each hysteresis release point. A design that used the wrong inequality, or applied hysteresis on the set side, would raise or release the event one step off. It sends a clear while the critical alarm is active, and a clear in shutdown. A design that let the first one through, or ignored the second, would drop or keep the event at the wrong moment. It also moves a limit with no sample flowing and uses negative temperatures. These catch a design that waits for the next sample or compares without sign.

// File: rtl/therm_evt_pkg.sv
package therm_evt_pkg;

  typedef struct packed {
    logic crit;
    logic hi;
    logic lo;
  } trip_t;

  typedef struct packed {
    logic crit;
    logic above;
    logic below;
  } alarm_t;

  typedef enum logic {
    EVT_LEVEL = 1'b0,
    EVT_LATCH = 1'b1
  } evt_mode_e;

endpackage

// File: rtl/therm_sample_hold.sv
module therm_sample_hold #(
  parameter int TEMP_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              shdn,
  input  logic [TEMP_W-1:0] temp_in,
  output logic              ready,
  output logic [TEMP_W-1:0] temp_q
);

  assign ready = ~shdn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               temp_q <= '0;
    else if (valid && ready)  temp_q <= temp_in;
  end

endmodule

// File: rtl/therm_trip_cmp.sv
module therm_trip_cmp
  import therm_evt_pkg::*;
#(
  parameter int TEMP_W    = 13,
  parameter int LIM_W     = 10,
  parameter int LIM_SHIFT = 2,
  parameter int HYST_UNIT = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shdn,
  input  logic [TEMP_W-1:0] temp_q,
  input  logic [LIM_W-1:0]  lim_hi,
  input  logic [LIM_W-1:0]  lim_lo,
  input  logic [LIM_W-1:0]  lim_crit,
  input  logic [1:0]        hyst_sel,
  output trip_t             trip,
  output alarm_t            alm_q,
  output alarm_t            alm_n
);

  localparam int SPAN   = (TEMP_W > LIM_W + LIM_SHIFT) ? TEMP_W : LIM_W + LIM_SHIFT;
  localparam int EW     = SPAN + 2;
  localparam int N_LIM  = 3;
  localparam int IX_CRT = 0;
  localparam int IX_HI  = 1;
  localparam int IX_LO  = 2;

  logic        [LIM_W-1:0] lim_raw [N_LIM];
  logic signed [EW-1:0]    lim_ext [N_LIM];
  logic signed [EW-1:0]    rel_pt  [N_LIM];
  logic signed [EW-1:0]    t_ext;
  logic signed [EW-1:0]    hy;

  assign lim_raw[IX_CRT] = lim_crit;
  assign lim_raw[IX_HI]  = lim_hi;
  assign lim_raw[IX_LO]  = lim_lo;

  assign t_ext = $signed({{(EW-TEMP_W){temp_q[TEMP_W-1]}}, temp_q});
  assign hy    = (hyst_sel == 2'd0) ? '0 : EW'(HYST_UNIT << (hyst_sel - 2'd1));

  for (genvar g = 0; g < N_LIM; g++) begin : g_lim
    assign lim_ext[g] = $signed({{(EW-LIM_W){lim_raw[g][LIM_W-1]}}, lim_raw[g]}) <<< LIM_SHIFT;
    assign rel_pt[g]  = lim_ext[g] - hy;
  end

  assign trip.crit = (t_ext >= lim_ext[IX_CRT]);
  assign trip.hi   = (t_ext >  lim_ext[IX_HI]);
  assign trip.lo   = (t_ext <  lim_ext[IX_LO]);

  always_comb begin
    alm_n = alm_q;
    if (!shdn) begin
      if (trip.crit)                    alm_n.crit  = 1'b1;
      else if (t_ext < rel_pt[IX_CRT])  alm_n.crit  = 1'b0;
      if (trip.hi)                      alm_n.above = 1'b1;
      else if (t_ext <= rel_pt[IX_HI])  alm_n.above = 1'b0;
      if (t_ext < rel_pt[IX_LO])        alm_n.below = 1'b1;
      else if (!trip.lo)                alm_n.below = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alm_q <= '0;
    else        alm_q <= alm_n;
  end

endmodule

// File: rtl/therm_evt_ctl.sv
module therm_evt_ctl
  import therm_evt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  alarm_t alm_q,
  input  alarm_t alm_n,
  input  logic   latch_mode,
  input  logic   crit_only,
  input  logic   shdn,
  input  logic   clr,
  input  logic   evt_en,
  input  logic   evt_pol,
  output logic   evt_status,
  output logic   evt_pull
);

  evt_mode_e mode;
  logic      win_chg, crossing, clr_ok, comp_n, latch_q, latch_n, evt_q, evt_n;

  assign mode     = evt_mode_e'(latch_mode);
  assign win_chg  = (alm_n.above ^ alm_q.above) | (alm_n.below ^ alm_q.below);
  assign crossing = (~crit_only & win_chg) | (alm_n.crit ^ alm_q.crit);
  assign clr_ok   = clr & ~alm_n.crit;
  assign comp_n   = alm_n.crit | (~crit_only & (alm_n.above | alm_n.below));

  always_comb begin
    latch_n = 1'b0;
    evt_n   = evt_q;
    if (mode == EVT_LATCH) begin
      if (shdn) begin
        latch_n = latch_q & ~clr_ok;
        evt_n   = evt_q & ~clr_ok;
      end else begin
        latch_n = crossing | (latch_q & ~clr_ok);
        evt_n   = latch_n | alm_n.crit;
      end
    end else if (!shdn) begin
      evt_n = comp_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      latch_q <= latch_n;
      evt_q   <= evt_n;
    end
  end

  assign evt_status = evt_en & evt_q;
  assign evt_pull   = evt_status ^ evt_pol;

endmodule

// File: rtl/therm_evt_cmp.sv
module therm_evt_cmp
  import therm_evt_pkg::*;
#(
  parameter int TEMP_W    = 13,
  parameter int LIM_W     = 10,
  parameter int LIM_SHIFT = 2,
  parameter int HYST_UNIT = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_valid,
  output logic              samp_ready,
  input  logic [TEMP_W-1:0] samp_temp,
  input  logic [LIM_W-1:0]  lim_hi,
  input  logic [LIM_W-1:0]  lim_lo,
  input  logic [LIM_W-1:0]  lim_crit,
  input  logic              cfg_latch_mode,
  input  logic              cfg_crit_only,
  input  logic [1:0]        cfg_hyst,
  input  logic              cfg_evt_en,
  input  logic              cfg_evt_pol,
  input  logic              cfg_shdn,
  input  logic              evt_clr,
  output logic              trip_crit,
  output logic              trip_hi,
  output logic              trip_lo,
  output logic              evt_status,
  output logic              evt_pull
);

  logic [TEMP_W-1:0] temp_q;
  trip_t             trip;
  alarm_t            alm_q, alm_n;

  therm_sample_hold #(.TEMP_W(TEMP_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .valid(samp_valid), .shdn(cfg_shdn),
    .temp_in(samp_temp), .ready(samp_ready), .temp_q(temp_q)
  );

  therm_trip_cmp #(
    .TEMP_W(TEMP_W), .LIM_W(LIM_W), .LIM_SHIFT(LIM_SHIFT), .HYST_UNIT(HYST_UNIT)
  ) u_cmp (
    .clk(clk), .rst_n(rst_n), .shdn(cfg_shdn), .temp_q(temp_q),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .lim_crit(lim_crit), .hyst_sel(cfg_hyst),
    .trip(trip), .alm_q(alm_q), .alm_n(alm_n)
  );

  therm_evt_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .alm_q(alm_q), .alm_n(alm_n),
    .latch_mode(cfg_latch_mode), .crit_only(cfg_crit_only), .shdn(cfg_shdn),
    .clr(evt_clr), .evt_en(cfg_evt_en), .evt_pol(cfg_evt_pol),
    .evt_status(evt_status), .evt_pull(evt_pull)
  );

  assign trip_crit = trip.crit;
  assign trip_hi   = trip.hi;
  assign trip_lo   = trip.lo;

endmodule

// File: rtl/therm_evt_cmp_chk.sv
module therm_evt_cmp_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_shdn,
  input logic evt_clr,
  input logic cfg_latch_mode,
  input logic cfg_crit_only,
  input logic cfg_evt_en,
  input logic cfg_evt_pol,
  input logic trip_crit,
  input logic trip_hi,
  input logic samp_ready,
  input logic evt_status,
  input logic evt_pull
);

  AST_CRIT_FORCES_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && trip_crit && !cfg_shdn) && cfg_evt_en) |-> evt_status); // R7

  AST_LEVEL_ABOVE_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && !cfg_shdn && !cfg_latch_mode && !cfg_crit_only && trip_hi) && cfg_evt_en)
      |-> evt_status); // R4

  AST_DISABLED_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_evt_en |-> (evt_pull == cfg_evt_pol)); // R8

  AST_SHDN_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_shdn |-> !samp_ready); // R9

  AST_SHDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && cfg_shdn && !evt_clr) && $stable(cfg_evt_en)) |-> $stable(evt_status)); // R9

endmodule

bind therm_evt_cmp therm_evt_cmp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_shdn(cfg_shdn), .evt_clr(evt_clr),
  .cfg_latch_mode(cfg_latch_mode), .cfg_crit_only(cfg_crit_only),
  .cfg_evt_en(cfg_evt_en), .cfg_evt_pol(cfg_evt_pol), .trip_crit(trip_crit),
  .trip_hi(trip_hi), .samp_ready(samp_ready), .evt_status(evt_status),
  .evt_pull(evt_pull)
);

// File: tb/therm_evt_cmp_tb.sv
module therm_evt_cmp_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 5000;
  localparam int NV         = 31;

  // {latch, crit_only, en, pol, hyst[1:0], shdn, clr, temp[12:0], trip{crit,hi,lo}, status, pull}
  // Limits for the table: high 80 C (320), low 10 C (40), critical 100 C (400)
  localparam logic [25:0] VEC [NV] = '{
    {1'b0,1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,13'd400 ,3'b000,1'b0,1'b0},
    {1'b0,1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,13'd1281,3'b010,1'b1,1'b1},
    {1'b0,1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,13'd1280,3'b000,1'b0,1'b0},
    {1'b0,1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,13'd159 ,3'b001,1'b1,1'b1},
    {1'b0,1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,13'd160 ,3'b000,1'b0,1'b0},
    {1'b0,1'b0,1'b1,1'b0,2'd1,1'b0,1'b0,13'd1281,3'b010,1'b1,1'b1},
    {1'b0,1'b0,1'b1,1'b0,2'd1,1'b0,1'b0,13'd1270,3'b000,1'b1,1'b1},
    {1'b0,1'b0,1'b1,1'b0,2'd1,1'b0,1'b0,13'd1256,3'b000,1'b0,1'b0},
    {1'b0,1'b0,1'b1,1'b0,2'd1,1'b0,1'b0,13'd150 ,3'b001,1'b0,1'b0},
    {1'b0,1'b0,1'b1,1'b0,2'd1,1'b0,1'b0,13'd135 ,3'b001,1'b1,1'b1},
    {1'b0,1'b0,1'b1,1'b0,2'd1,1'b0,1'b0,13'd150 ,3'b001,1'b1,1'b1},
    {1'b0,1'b0,1'b1,1'b0,2'd1,1'b0,1'b0,13'd160 ,3'b000,1'b0,1'b0},
    {1'b0,1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,13'd1500,3'b010,1'b0,1'b0},
    {1'b0,1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,13'd1600,3'b110,1'b1,1'b1},
    {1'b0,1'b1,1'b1,1'b1,2'd0,1'b0,1'b0,13'd1600,3'b110,1'b1,1'b0},
    {1'b0,1'b1,1'b1,1'b1,2'd0,1'b0,1'b0,13'd400 ,3'b000,1'b0,1'b1},
    {1'b0,1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,13'd1281,3'b010,1'b0,1'b1},
    {1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,13'd1281,3'b010,1'b0,1'b0},
    {1'b1,1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,13'd1281,3'b010,1'b0,1'b0},
    {1'b1,1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,13'd1000,3'b000,1'b1,1'b1},
    {1'b1,1'b0,1'b1,1'b0,2'd0,1'b0,1'b1,13'd1000,3'b000,1'b0,1'b0},
    {1'b1,1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,13'd1281,3'b010,1'b1,1'b1},
    {1'b1,1'b0,1'b1,1'b0,2'd0,1'b0,1'b1,13'd1281,3'b010,1'b0,1'b0},
    {1'b1,1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,13'd1700,3'b110,1'b1,1'b1},
    {1'b1,1'b0,1'b1,1'b0,2'd0,1'b0,1'b1,13'd1700,3'b110,1'b1,1'b1},
    {1'b1,1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,13'd1500,3'b010,1'b1,1'b1},
    {1'b1,1'b0,1'b1,1'b0,2'd0,1'b0,1'b1,13'd1500,3'b010,1'b0,1'b0},
    {1'b1,1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,13'd1000,3'b000,1'b1,1'b1},
    {1'b1,1'b0,1'b1,1'b0,2'd0,1'b1,1'b0,13'd1281,3'b000,1'b1,1'b1},
    {1'b1,1'b0,1'b1,1'b0,2'd0,1'b1,1'b1,13'd1281,3'b000,1'b0,1'b0},
    {1'b1,1'b0,1'b1,1'b0,2'd0,1'b0,1'b0,13'd1281,3'b010,1'b1,1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        samp_valid = 1'b0;
  logic        samp_ready;
  logic [12:0] samp_temp = '0;
  logic [9:0]  lim_hi = 10'd320;
  logic [9:0]  lim_lo = 10'd40;
  logic [9:0]  lim_crit = 10'd400;
  logic        cfg_latch_mode = 1'b0;
  logic        cfg_crit_only = 1'b0;
  logic [1:0]  cfg_hyst = 2'd0;
  logic        cfg_evt_en = 1'b0;
  logic        cfg_evt_pol = 1'b0;
  logic        cfg_shdn = 1'b0;
  logic        evt_clr = 1'b0;
  logic        trip_crit, trip_hi, trip_lo, evt_status, evt_pull;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  therm_evt_cmp dut_i (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_ready(samp_ready),
    .samp_temp(samp_temp), .lim_hi(lim_hi), .lim_lo(lim_lo), .lim_crit(lim_crit),
    .cfg_latch_mode(cfg_latch_mode), .cfg_crit_only(cfg_crit_only), .cfg_hyst(cfg_hyst),
    .cfg_evt_en(cfg_evt_en), .cfg_evt_pol(cfg_evt_pol), .cfg_shdn(cfg_shdn),
    .evt_clr(evt_clr), .trip_crit(trip_crit), .trip_hi(trip_hi), .trip_lo(trip_lo),
    .evt_status(evt_status), .evt_pull(evt_pull)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic string evt_tag(input int i);
    if (i < 5)       return "R4";
    else if (i < 12) return "R3";
    else if (i < 16) return "R5";
    else if (i < 18) return "R8";
    else if (i < 23) return "R6";
    else if (i < 27) return "R7";
    else             return "R9";
  endfunction

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11", "status in reset", int'(evt_status), 0);
    chk("R11", "pull in reset pol0", int'(evt_pull), 0);
    cfg_evt_pol = 1'b1;
    #1;
    chk("R11", "pull in reset pol1", int'(evt_pull), 1);
    chk("R11", "ready in reset", int'(samp_ready), 1);
    cfg_evt_pol = 1'b0;
    rst_n = 1'b1;
    samp_valid = 1'b1;
    @(negedge clk);

    // Table walk: apply, two edges, check
    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      cfg_latch_mode = v[25];
      cfg_crit_only  = v[24];
      cfg_evt_en     = v[23];
      cfg_evt_pol    = v[22];
      cfg_hyst       = v[21:20];
      cfg_shdn       = v[19];
      evt_clr        = v[18];
      samp_temp      = v[17:5];
      @(posedge clk);
      @(negedge clk);
      evt_clr = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk((i == 16 || i == 17) ? "R2" : "R1", $sformatf("trip vec %0d", i), int'({trip_crit, trip_hi, trip_lo}), int'(v[4:2]));
      chk(evt_tag(i), $sformatf("status vec %0d", i), int'(evt_status), int'(v[1]));
      chk(evt_tag(i), $sformatf("pull vec %0d", i), int'(evt_pull), int'(v[0]));
    end

    // Back to level mode, settled below the high limit
    cfg_latch_mode = 1'b0; cfg_crit_only = 1'b0; cfg_evt_en = 1'b1;
    cfg_evt_pol = 1'b0; cfg_hyst = 2'd0; samp_temp = 13'd1000;
    settle(3);
    chk("R4", "settled level", int'(evt_status), 0);

    // R12: trip after one edge, event after the second
    samp_temp = 13'd1281;
    @(posedge clk); @(negedge clk);
    chk("R12", "trip_hi after take", int'(trip_hi), 1);
    chk("R12", "event not yet", int'(evt_status), 0);
    @(posedge clk); @(negedge clk);
    chk("R12", "event one edge later", int'(evt_status), 1);
    samp_temp = 13'd1000;
    settle(3);

    // R10: limit change with no sample flowing
    samp_valid = 1'b0;
    lim_hi = 10'd240;
    #1;
    chk("R10", "trip_hi same cycle", int'(trip_hi), 1);
    chk("R10", "event before edge", int'(evt_status), 0);
    @(posedge clk); @(negedge clk);
    chk("R10", "event after edge", int'(evt_status), 1);
    lim_hi = 10'd320;
    samp_valid = 1'b1;
    settle(3);

    // R1: negative values, low limit -1 C (-16 sample LSBs)
    lim_lo = 10'h3FC;
    samp_temp = 13'h1FFF;
    settle(2);
    chk("R1", "lo at -0.0625 C", int'(trip_lo), 0);
    samp_temp = 13'h1FEF;
    settle(2);
    chk("R1", "lo at -1.0625 C", int'(trip_lo), 1);
    samp_temp = 13'h1FF0;
    settle(2);
    chk("R1", "lo at exactly -1 C", int'(trip_lo), 0);
    lim_lo = 10'd40;
    samp_temp = 13'd1000;
    settle(3);

    // R9: shutdown refuses samples, held value unchanged
    cfg_shdn = 1'b1;
    #1;
    chk("R9", "ready in shutdown", int'(samp_ready), 0);
    samp_temp = 13'd1700;
    settle(2);
    chk("R9", "crit trip frozen", int'(trip_crit), 0);
    cfg_shdn = 1'b0;
    #1;
    chk("R9", "ready after shutdown", int'(samp_ready), 1);
    settle(2);
    chk("R9", "sample taken after shutdown", int'(trip_crit), 1);

    finish_run();
  end

endmodule